// File: doc/BRIEF.md
# Iterative Carry-less Multiply Unit

This block multiplies two 64-bit operands as polynomials over GF(2). Partial products are combined with XOR, and no carries are propagated. The full product is 128 bits wide. A half-select input chosen when an operation is accepted decides which 64 bits are returned: the low half or the high half. The first operand always comes from the element input. The second operand comes from one of two sources, picked per operation: the per-element vector input, or a scalar input that the surrounding datapath applies to every element in turn.

The unit is iterative and works on one multiplier bit per clock, starting from the most significant bit. The accumulator is shifted left by one each cycle, and the second operand is XORed in whenever the current multiplier bit is set. After 64 steps the accumulator holds the whole product. The selected half is then registered, and a done strobe is raised for one cycle.

The controller has three states:
- `S_IDLE`: ready for operands.
- `S_RUN`: 64 shift-and-XOR steps.
- `S_DONE`: result valid for one cycle.

Transitions:
- `IDLE→RUN` on an accepted handshake.
- `RUN→RUN` while the step counter is below 63.
- `RUN→DONE` on step 63.
- `DONE→IDLE` unconditionally.

Top module: `clmul_unit`

## Requirements
- R1: With `sel_high`=0, the result equals the XOR, over every set bit j (0..63) of `op_a`, of the second operand shifted left by j, with bits above position 63 dropped.
- R2: With `sel_high`=1, the result equals bits 127..64 of the full 128-bit carry-less product. Bit 0 of `op_a` never affects it: two operands differing only in bit 0 of `op_a` give equal high results.
- R3: The second operand is `scalar_b` when `use_scalar`=1 and `vec_b` when `use_scalar`=0. All operand and select inputs are captured on the accepting clock edge.
- R4: `out_done` is high for exactly one cycle. That cycle follows the 64th rising edge after the accepting edge.
- R5: `in_ready` is high only in the idle state. A handshake presented while the unit is busy (`in_valid`=1, `in_ready`=0) is ignored and does not change the result in progress.
- R6: `out_result` changes only on the edge that raises `out_done`, and holds its value until the next completion.
- R7: After reset, `in_ready`=1, `out_done`=0 and `out_result`=0.
- R8: A zero operand gives zero in both halves. A second operand of 1 gives `op_a` in the low half and zero in the high half.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands and selects presented |
| in_ready | output | 1 | Unit idle; handshake accepted this cycle |
| op_a | input | 64 | First operand (multiplier) |
| vec_b | input | 64 | Per-element second operand |
| scalar_b | input | 64 | Broadcast second operand |
| use_scalar | input | 1 | 1 selects `scalar_b`, 0 selects `vec_b` |
| sel_high | input | 1 | 1 returns product bits 127..64, 0 returns bits 63..0 |
| out_done | output | 1 | One-cycle completion strobe |
| out_result | output | 64 | Registered selected half of the product |

## Verification
A stuck or skipped step counter shows up at the ports as `out_done` arriving earlier or later than 64 cycles after acceptance. The per-clock model flags this on the first cycle where the timing differs, along with `in_ready` returning too soon or too late. A corrupted accumulator or a wrong operand latch shows up only on the completion cycle, as a wrong `out_result`. Each operation therefore exposes such a fault at most 65 cycles after acceptance. Corner operands such as bit 0 only, bit 63 only, all ones and the value 1 in both halves are used so that faults in the shift direction and in half selection cannot hide.

// File: rtl/clmul_pkg.sv
package clmul_pkg;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_RUN  = 2'd1,
        S_DONE = 2'd2
    } clmul_state_t;

endpackage

// File: rtl/clmul_ctrl.sv
module clmul_ctrl
    import clmul_pkg::*;
#(
    parameter int W = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    output logic in_ready,
    output logic load,
    output logic step,
    output logic last,
    output logic done
);
    localparam int CW = $clog2(W);

    clmul_state_t state, state_n;
    logic [CW-1:0] cnt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            state <= state_n;
        end
    end

    // step counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= '0;
        end else if (step) begin
            cnt <= cnt + 1'b1;
        end
    end

    // next-state
    always_comb begin
        state_n = state;
        unique case (state)
            S_IDLE: if (in_valid) state_n = S_RUN;
            S_RUN:  if (cnt == CW'(W-1)) state_n = S_DONE;
            S_DONE: state_n = S_IDLE;
            default: state_n = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        in_ready = 1'b0;
        load     = 1'b0;
        step     = 1'b0;
        last     = 1'b0;
        done     = 1'b0;
        unique case (state)
            S_IDLE: begin
                in_ready = 1'b1;
                load     = in_valid;
            end
            S_RUN: begin
                step = 1'b1;
                last = (cnt == CW'(W-1));
            end
            S_DONE: done = 1'b1;
            default: ;
        endcase
    end

    // R4
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R4
    done_after_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(last));
    // R5
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

endmodule

// File: rtl/clmul_dp.sv
module clmul_dp #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         step,
    input  logic         last,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] vec_b,
    input  logic [W-1:0] scalar_b,
    input  logic         use_scalar,
    input  logic         sel_high,
    output logic [W-1:0] result
);
    localparam int PW = 2 * W;

    logic [W-1:0]  a_sh;
    logic [W-1:0]  b_q;
    logic          hi_q;
    logic [PW-1:0] acc;
    logic [PW-1:0] acc_n;
    logic [PW-1:0] addend;

    // R3: second operand source chosen at accept
    logic [W-1:0] b_sel;
    assign b_sel = use_scalar ? scalar_b : vec_b;

    // one shift-and-XOR step, multiplier scanned MSB first
    assign addend = a_sh[W-1] ? {{W{1'b0}}, b_q} : '0;
    assign acc_n  = {acc[PW-2:0], 1'b0} ^ addend;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_sh <= '0;
            b_q  <= '0;
            hi_q <= 1'b0;
            acc  <= '0;
        end else if (load) begin
            a_sh <= op_a;
            b_q  <= b_sel;
            hi_q <= sel_high;
            acc  <= '0;
        end else if (step) begin
            a_sh <= {a_sh[W-2:0], 1'b0};
            acc  <= acc_n;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result <= '0;
        end else if (last) begin
            result <= hi_q ? acc_n[PW-1:W] : acc_n[W-1:0];
        end
    end

    // R1: a zero multiplier leaves the accumulator empty
    zero_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && op_a == '0) |=> (a_sh == '0 && acc == '0));

endmodule

// File: rtl/clmul_unit.sv
module clmul_unit #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] vec_b,
    input  logic [W-1:0] scalar_b,
    input  logic         use_scalar,
    input  logic         sel_high,
    output logic         out_done,
    output logic [W-1:0] out_result
);
    logic load, step, last;

    clmul_ctrl #(.W(W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_valid(in_valid),
        .in_ready(in_ready),
        .load    (load),
        .step    (step),
        .last    (last),
        .done    (out_done)
    );

    clmul_dp #(.W(W)) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .step      (step),
        .last      (last),
        .op_a      (op_a),
        .vec_b     (vec_b),
        .scalar_b  (scalar_b),
        .use_scalar(use_scalar),
        .sel_high  (sel_high),
        .result    (out_result)
    );

    // R6
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_done |-> $stable(out_result));

endmodule

// File: tb/clmul_unit_tb.sv
module clmul_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [63:0] op_a = '0, vec_b = '0, scalar_b = '0;
    logic        use_scalar = 1'b0, sel_high = 1'b0;
    logic        out_done;
    logic [63:0] out_result;

    int total = 0, bad = 0, cycles = 0;
    string tag = "R7";

    always #4 clk = ~clk;

    clmul_unit u_dut (.*);

    function automatic logic [63:0] ref_clmul(input logic [63:0] a, input logic [63:0] b,
                                              input logic hi);
        logic [127:0] p = '0;
        for (int j = 0; j < 64; j++)
            if (a[j]) p = p ^ ({64'd0, b} << j);
        return hi ? p[127:64] : p[63:0];
    endfunction

    // behavioural model: 0 idle, 1 busy, 2 done
    int          m_st = 0, m_left = 0;
    logic [63:0] m_exp = '0, m_last = '0;

    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_st = 0; m_last = '0;
        end else begin
            case (m_st)
                0: if (in_valid) begin
                    m_exp  = ref_clmul(op_a, use_scalar ? scalar_b : vec_b, sel_high);
                    m_left = 64; m_st = 1;
                end
                1: begin
                    m_left--;
                    if (m_left == 0) begin m_st = 2; m_last = m_exp; end
                end
                default: m_st = 0;
            endcase
        end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            check("R5 ready", {63'd0, in_ready}, {63'd0, m_st == 0});
            check("R4 done", {63'd0, out_done}, {63'd0, m_st == 2});
            if (m_st == 2) check(tag, out_result, m_exp);
            else check("R6 hold", out_result, m_last);
        end
    end

    task automatic run_op(input string t, input logic [63:0] a, input logic [63:0] vb,
                          input logic [63:0] sb, input logic sc, input logic hi,
                          input int busy_hold);
        @(negedge clk);
        tag = t;
        op_a = a; vec_b = vb; scalar_b = sb; use_scalar = sc; sel_high = hi;
        in_valid = 1'b1;
        @(negedge clk);
        if (busy_hold > 0) begin
            // R5: keep a competing handshake up while busy
            op_a = ~a; vec_b = vb ^ 64'h5a5a; scalar_b = ~sb; use_scalar = ~sc;
            sel_high = ~hi;
            repeat (busy_hold) @(negedge clk);
        end
        in_valid = 1'b0;
        while (!(out_done === 1'b1)) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R7 reset state
        check("R7 ready", {63'd0, in_ready}, 64'd1);
        check("R7 done", {63'd0, out_done}, 64'd0);
        check("R7 result", out_result, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        run_op("R8 zero a lo", 64'd0, 64'hdead_beef_1234_5678, 0, 0, 0, 0);
        run_op("R8 zero a hi", 64'd0, 64'hffff_ffff_ffff_ffff, 0, 0, 1, 0);
        run_op("R8 zero b hi", 64'hffff_ffff_ffff_ffff, 64'd0, 0, 0, 1, 0);
        run_op("R8 one lo", 64'h0123_4567_89ab_cdef, 64'd1, 0, 0, 0, 0);
        run_op("R8 one hi", 64'h0123_4567_89ab_cdef, 64'd1, 0, 0, 1, 0);
        run_op("R2 bit0 only hi", 64'd1, 64'hffff_ffff_ffff_ffff, 0, 0, 1, 0);
        run_op("R2 bit63 hi", 64'h8000_0000_0000_0000, 64'hffff_ffff_ffff_ffff, 0, 0, 1, 0);
        run_op("R1 bit63 lo", 64'h8000_0000_0000_0000, 64'hffff_ffff_ffff_ffff, 0, 0, 0, 0);
        run_op("R1 ones lo", '1, '1, 0, 0, 0, 0);
        run_op("R2 ones hi", '1, '1, 0, 0, 1, 0);
        run_op("R2 ones bit0 clr hi", 64'hffff_ffff_ffff_fffe, '1, 0, 0, 1, 0);
        run_op("R3 scalar lo", 64'h0f0f_0000_1111_8001, 64'h1, 64'h9876_5432_10fe_dcba, 1, 0, 0);
        run_op("R3 scalar hi", 64'h0f0f_0000_1111_8001, 64'h1, 64'h9876_5432_10fe_dcba, 1, 1, 0);
        run_op("R5 busy ignored", 64'h1357_9bdf_2468_ace0, 64'h0fed_cba9_8765_4321, 0, 0, 0, 30);
        for (int i = 0; i < 40; i++) begin
            logic [63:0] a, b, s;
            a = {$urandom, $urandom}; b = {$urandom, $urandom}; s = {$urandom, $urandom};
            run_op((i % 2) ? "R2 random" : "R1 random", a, b, s, i[2], i[0], 0);
        end
        repeat (3) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        while (cycles < 100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog act=hung exp=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule